// File: doc/BRIEF.md
# Segment Boundary Extremes Tracker

This block sits beside the output of a pipelined converter whose raw code range is split into equal segments by its most significant bits. It watches every valid raw code and, for each segment, keeps the largest and the smallest code observed since the last clear. From these extremes it reports, for every boundary between two adjacent segments, how far apart the codes on the two sides are: the smallest code seen in the upper segment minus the largest code seen in the lower segment. A difference of 1 means the transfer curve is continuous at that boundary. A larger value shows missing codes there, so a later stage can derive correction values from it.

The tracker needs no test stimulus and never holds up the data path. It only observes the live codes. A synchronous clear starts a new observation window. A per-boundary valid flag tells the consumer whether both neighbouring segments have been hit inside the current window.

Top module: `seg_boundary_tracker`

## Requirements
- R1: After reset, and in the cycle after a clear, every `gap_valid` bit is 0 and every `gap_size` field is 0.
- R2: The segment of a code is its top SEG_BITS bits. A valid code changes only the extremes of that segment, so only the gaps that border it can change.
- R3: For segment k, the lower side of boundary k keeps the largest code seen since the last clear, and the upper side of boundary k-1 keeps the smallest.
- R4: When both neighbours are seen, `gap_size` field k (bits k*CODE_W upward) equals the smallest code seen in segment k+1 minus the largest code seen in segment k.
- R5: `gap_valid[k]` is 1 exactly when both segment k and segment k+1 have been hit since the last clear. While it is 0, field k reads 0.
- R6: A code presented while `code_valid` is 0 changes no extreme, flag or output.
- R7: `clear` is synchronous and wins over a valid code in the same cycle. That code is dropped.
- R8: A valid code is reflected on the outputs right after the clock edge that samples it. A new code is accepted every cycle with no stall.
- R9: The lowest and the highest code of a segment are tracked like any other. A single hit makes that code both the minimum and the maximum of its segment, so adjacent boundary codes give a gap of 1.
- R10: A negative difference is reported as 0. It cannot arise from codes that have been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Starts a new observation window |
| code_valid | input | 1 | Qualifies `raw_code` in this cycle |
| raw_code | input | CODE_W | Uncorrected converter output code |
| gap_size | output | (2**SEG_BITS-1)*CODE_W | Boundary distances, field k at bits k*CODE_W upward |
| gap_valid | output | 2**SEG_BITS-1 | Both neighbours of boundary k were hit |

## Verification
The hardest case to reach is a boundary where both sides hold their extreme codes, that is, the highest code of one segment and the lowest code of the next. Uniform random codes rarely land there. A second hard case is a clear that arrives in the same cycle as a valid code. The stimulus therefore mixes fully random codes with codes drawn only from a few values on each side of the segment edges, and it injects clears at random, some of them alongside valid codes. Every step is compared against a model of the per-segment extremes.

// File: rtl/seg_track_pkg.sv
package seg_track_pkg;
   // lowest code of segment idx
   function automatic int unsigned seg_low(input int unsigned idx, input int unsigned code_w,
                                           input int unsigned seg_bits);
      return idx << (code_w - seg_bits);
   endfunction

   // highest code of segment idx
   function automatic int unsigned seg_high(input int unsigned idx, input int unsigned code_w,
                                            input int unsigned seg_bits);
      return ((idx + 1) << (code_w - seg_bits)) - 1;
   endfunction
endpackage

// File: rtl/seg_hit_flags.sv
module seg_hit_flags #(
   parameter int unsigned SEG_BITS = 3,
   localparam int unsigned NSEG    = 1 << SEG_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                code_valid,
   input  logic [SEG_BITS-1:0] seg_sel,
   output logic [NSEG-1:0]     hit,
   output logic [NSEG-1:0]     seen
);
   always_comb begin
      hit = '0;
      if (code_valid) hit[seg_sel] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) seen <= '0;
      else                 seen <= seen | hit;
   end

   // R2
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   // R1
   seen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (seen == '0));

   // R6
   seen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!code_valid && !clear) |=> $stable(seen));
endmodule

// File: rtl/seg_extreme_reg.sv
module seg_extreme_reg
   import seg_track_pkg::*;
#(
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned SEG_BITS = 3,
   parameter int unsigned SEG_IDX  = 0,
   parameter bit          KEEP_MAX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              hit,
   input  logic [CODE_W-1:0] raw_code,
   output logic [CODE_W-1:0] ext
);
   localparam logic [CODE_W-1:0] SEG_LO = CODE_W'(seg_low(SEG_IDX, CODE_W, SEG_BITS));
   localparam logic [CODE_W-1:0] SEG_HI = CODE_W'(seg_high(SEG_IDX, CODE_W, SEG_BITS));
   // start at the far end so that the first hit always replaces it
   localparam logic [CODE_W-1:0] START = KEEP_MAX ? SEG_LO : SEG_HI;

   logic better;

   generate
      if (KEEP_MAX) begin : g_max
         assign better = raw_code > ext;
      end else begin : g_min
         assign better = raw_code < ext;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clear)    ext <= START;
      else if (hit && better) ext <= raw_code;
   end

   generate
      if (KEEP_MAX) begin : g_max_chk
         // R3
         ext_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> (ext >= $past(ext)));
      end else begin : g_min_chk
         // R3
         ext_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> (ext <= $past(ext)));
      end
   endgenerate

   // R8
   ext_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clear && better) |=> (ext == $past(raw_code)));

   // R2
   ext_in_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext >= SEG_LO) && (ext <= SEG_HI));
endmodule

// File: rtl/seg_boundary_tracker.sv
module seg_boundary_tracker #(
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned SEG_BITS = 3,
   localparam int unsigned NSEG    = 1 << SEG_BITS,
   localparam int unsigned NGAP    = NSEG - 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   code_valid,
   input  logic [CODE_W-1:0]      raw_code,
   output logic [NGAP*CODE_W-1:0] gap_size,
   output logic [NGAP-1:0]        gap_valid
);
   generate
      if (SEG_BITS < 1 || SEG_BITS >= CODE_W) begin : g_bad_cfg
         $error("SEG_BITS must lie between 1 and CODE_W-1");
      end
   endgenerate

   logic [NSEG-1:0]   hit;
   logic [NSEG-1:0]   seen;
   logic [CODE_W-1:0] seg_max [NGAP];
   logic [CODE_W-1:0] seg_min [NGAP];   // index k holds segment k+1

   seg_hit_flags #(.SEG_BITS(SEG_BITS)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .code_valid (code_valid),
      .seg_sel    (raw_code[CODE_W-1 -: SEG_BITS]),
      .hit        (hit),
      .seen       (seen)
   );

   generate
      for (genvar k = 0; k < NGAP; k++) begin : g_bnd
         logic [CODE_W:0] diff;
         logic            ok;

         seg_extreme_reg #(
            .CODE_W(CODE_W), .SEG_BITS(SEG_BITS), .SEG_IDX(k), .KEEP_MAX(1'b1)
         ) u_lo_max (
            .clk(clk), .rst_n(rst_n), .clear(clear), .hit(hit[k]),
            .raw_code(raw_code), .ext(seg_max[k])
         );

         seg_extreme_reg #(
            .CODE_W(CODE_W), .SEG_BITS(SEG_BITS), .SEG_IDX(k+1), .KEEP_MAX(1'b0)
         ) u_hi_min (
            .clk(clk), .rst_n(rst_n), .clear(clear), .hit(hit[k+1]),
            .raw_code(raw_code), .ext(seg_min[k])
         );

         assign diff         = {1'b0, seg_min[k]} - {1'b0, seg_max[k]};
         assign ok           = seen[k] && seen[k+1];
         assign gap_valid[k] = ok;
         // a borrow means negative: clamp to zero
         assign gap_size[k*CODE_W +: CODE_W] = (ok && !diff[CODE_W]) ? diff[CODE_W-1:0] : '0;

         // R5
         gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !gap_valid[k] |-> (gap_size[k*CODE_W +: CODE_W] == '0));

         // R10
         gap_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gap_valid[k] |-> (gap_size[k*CODE_W +: CODE_W] != '0));
      end
   endgenerate

   // R7
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (gap_valid == '0));
endmodule

// File: tb/tb_seg_boundary_tracker.sv
module tb_seg_boundary_tracker;
   localparam int CW         = 10;
   localparam int SB         = 3;
   localparam int NS         = 1 << SB;
   localparam int NG         = NS - 1;
   localparam int OFF        = CW - SB;
   localparam int CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clear = 1'b0;
   logic              code_valid = 1'b0;
   logic [CW-1:0]     raw_code = '0;
   logic [NG*CW-1:0]  gap_size;
   logic [NG-1:0]     gap_valid;

   int checks = 0;
   int failures = 0;
   int mx [NS];
   int mn [NS];
   bit sn [NS];

   seg_boundary_tracker #(.CODE_W(CW), .SEG_BITS(SB)) dut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .code_valid(code_valid),
      .raw_code(raw_code), .gap_size(gap_size), .gap_valid(gap_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int exp_gap(input int k);
      if (sn[k] && sn[k+1]) return mn[k+1] - mx[k];
      return 0;
   endfunction

   task automatic model_clear();
      for (int s = 0; s < NS; s++) sn[s] = 1'b0;
   endtask

   // drive at a falling edge, let one rising edge sample, return at the next falling edge
   task automatic step(input bit v, input int c, input bit clr);
      int s;
      code_valid = v;
      raw_code   = CW'(c);
      clear      = clr;
      if (clr) model_clear();
      else if (v) begin
         s = c >> OFF;
         if (!sn[s]) begin mx[s] = c; mn[s] = c; end
         else begin
            if (c > mx[s]) mx[s] = c;
            if (c < mn[s]) mn[s] = c;
         end
         sn[s] = 1'b1;
      end
      @(negedge clk);
      code_valid = 1'b0;
      clear      = 1'b0;
   endtask

   task automatic check_all(input string req);
      for (int k = 0; k < NG; k++) begin
         int got;
         int exp;
         got = int'(gap_size[k*CW +: CW]);
         exp = exp_gap(k);
         checks++;
         if (gap_valid[k] !== (sn[k] && sn[k+1]) || got != exp) begin
            failures++;
            $display("FAIL %s boundary %0d: valid=%0b size=%0d expected valid=%0b size=%0d",
                     req, k, gap_valid[k], got, sn[k] && sn[k+1], exp);
         end
      end
   endtask

   function automatic int near_edge();
      int e;
      e = 1 + int'($urandom_range(NS-2, 0));
      return (e << OFF) - 3 + int'($urandom_range(5, 0));
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");

      // R9 single hit at the lowest code of segment 3
      step(1'b1, 3 << OFF, 1'b0);
      check_all("R9 single hit");
      // R4 R9 highest code of segment 2, boundary 2 gives 1
      step(1'b1, (3 << OFF) - 1, 1'b0);
      check_all("R4 R9 adjacent edge codes");
      // R6 invalid code into segment 4 has no effect
      step(1'b0, 4 << OFF, 1'b0);
      check_all("R6 invalid ignored");
      // R2 hit in segment 5 only touches its neighbours
      step(1'b1, (5 << OFF) + 17, 1'b0);
      check_all("R2 segment select");
      step(1'b1, (4 << OFF) + 5, 1'b0);
      check_all("R2 R8 fill segment 4");
      // R3 larger and smaller codes widen the extremes
      step(1'b1, (4 << OFF) + 100, 1'b0);
      check_all("R3 new max");
      step(1'b1, (5 << OFF) + 2, 1'b0);
      check_all("R3 new min");
      // R7 clear together with a valid code drops it
      step(1'b1, (6 << OFF) + 1, 1'b1);
      check_all("R7 clear wins");
      step(1'b0, 0, 1'b0);
      check_all("R1 after clear");
      // R8 back-to-back codes every cycle
      step(1'b1, 0, 1'b0);
      step(1'b1, (1 << OFF) + 9, 1'b0);
      check_all("R8 back to back");
      // R9 extremes of the whole range
      step(1'b1, (1 << CW) - 1, 1'b0);
      step(1'b1, (7 << OFF), 1'b0);
      step(1'b1, (6 << OFF) - 1, 1'b0);
      check_all("R9 range ends");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         bit clr;
         bit v;
         int c;
         clr = ($urandom_range(299, 0) == 0);
         v   = ($urandom_range(3, 0) != 0);
         c   = ($urandom_range(1, 0) == 0) ? int'($urandom_range((1 << CW) - 1, 0))
                                           : near_edge();
         step(v, c, clr);
         check_all(clr ? "R7 random clear" : "R3 R4 R5 random");
      end

      // R10 values stay non-negative after a dense sweep
      step(1'b0, 0, 1'b1);
      for (int c = 0; c < (1 << CW); c += 7) step(1'b1, c, 1'b0);
      check_all("R10 sweep");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule